// File: doc/BRIEF.md
# Chiplet control register bank

This block holds twelve 64-bit registers behind a single-cycle access port. Six control registers and two configuration registers can be reached in three ways. A plain write replaces the register. A set alias ORs the written bits into it. A clear alias removes the written bits from it. The four remaining registers (status, mask, protect mode and atomic lock) take plain reads and writes only.

Software uses the aliases to flip individual bits without a read-modify-write sequence. The aliases cannot be read back. A read of an alias, a read of an unmapped location, or any access that is not a full, aligned 8-byte transfer returns all ones and raises a one-cycle error flag.

Data on the port follows big-endian byte order. Byte offset 0 of a register is bits 63:56 of the data bus. Because every accepted access is a full 8-byte access, the bank applies no byte steering.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset, every register reads 0x0, err_o is low and rdata_o is 0x0.
- R2: The register index is addr_i shifted right by 3. An access is accepted only when size_i is 3 (8 bytes) and addr_i[2:0] is 0. Any other access pulses err_o, changes no register, and a read of that kind returns all ones.
- R3: Control registers 0 to 5 sit at indices 0x00 to 0x05. A write to one of these indices replaces the whole register.
- R4: Configuration register 0 sits at index 0x08 and configuration register 1 at index 0x09. A write to either index replaces the whole register.
- R5: A write to index base+0x10 of a control or configuration register sets that register to its old value OR the written data.
- R6: A write to index base+0x20 of a control or configuration register sets that register to its old value AND the inverse of the written data.
- R7: A read of a set or clear alias returns 0xFFFF_FFFF_FFFF_FFFF, pulses err_o and leaves every register unchanged.
- R8: Status (0x100), mask (0x101), protect mode (0x3FE) and atomic lock (0x3FF) are plain read/write registers with no aliases. Index 0x110, for example, is unmapped.
- R9: A read of an unmapped index returns all ones and pulses err_o. A write to an unmapped index pulses err_o and changes no register.
- R10: Read data appears on rdata_o on the cycle after the request and holds until the next read. A read issued the cycle after a write returns the written value.
- R11: err_o is high for exactly the one cycle after each erroneous request and low after every accepted access or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | log2 of the access size in bytes; 3 = 8 bytes |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 64 | Write data, big-endian |
| rdata_o | output | 64 | Registered read data |
| err_o | output | 1 | One-cycle access error flag |

## Verification
On every cycle the assertions check the following:
- Partial or misaligned accesses raise the error flag and leave every register intact.
- Alias reads return all ones with the error flag set.
- The set alias of control register 0 and the clear alias of configuration register 1 follow their update rules.
- A status read returns the stored value without error.
- Read data and the error flag stay quiet on idle cycles.

The directed scenarios cover the rest of the address map. These are the plain replace writes to every register, the aliases of the other registers, the unmapped holes next to the plain-only registers, write-then-read ordering on consecutive cycles, and confirmation through later reads that ignored writes left the registers unchanged.

// File: rtl/cb_pkg.sv
`timescale 1ns/1ps
package cb_pkg;
  localparam int SET_OFS  = 'h10;
  localparam int CLR_OFS  = 'h20;
  localparam int CFG_BASE = 'h08;
  localparam int N_PLAIN  = 4;
  localparam logic [1:0] SZ_8B = 2'd3;

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_SET, OP_CLR} op_e;

  typedef struct packed {
    logic       hit;
    logic       aliased;
    op_e        op;
    logic [3:0] slot;
  } dec_t;

  // indices of registers without aliases: status, mask, protect, lock
  function automatic int plain_idx(int p);
    case (p)
      0:       return 'h100;
      1:       return 'h101;
      2:       return 'h3FE;
      default: return 'h3FF;
    endcase
  endfunction
endpackage

// File: rtl/cb_decode.sv
`timescale 1ns/1ps
module cb_decode
  import cb_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int N_CTRL = 6,
  parameter int N_CFG  = 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output dec_t             dec_o
);
  localparam int N_AL = N_CTRL + N_CFG;

  always_comb begin
    dec_o = '{hit: 1'b0, aliased: 1'b0, op: OP_NONE, slot: 4'd0};
    for (int k = 0; k < N_AL; k++) begin
      int base;
      base = (k < N_CTRL) ? k : CFG_BASE + k - N_CTRL;
      if (int'(idx_i) == base) begin
        dec_o = '{hit: 1'b1, aliased: 1'b1, op: OP_WR, slot: 4'(k)};
      end else if (int'(idx_i) == base + SET_OFS) begin
        dec_o = '{hit: 1'b1, aliased: 1'b1, op: OP_SET, slot: 4'(k)};
      end else if (int'(idx_i) == base + CLR_OFS) begin
        dec_o = '{hit: 1'b1, aliased: 1'b1, op: OP_CLR, slot: 4'(k)};
      end
    end
    for (int p = 0; p < N_PLAIN; p++) begin
      if (int'(idx_i) == plain_idx(p)) begin
        dec_o = '{hit: 1'b1, aliased: 1'b0, op: OP_WR, slot: 4'(p)};
      end
    end
  end
endmodule

// File: rtl/cb_reg.sv
`timescale 1ns/1ps
module cb_reg
  import cb_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (we_i) begin
      case (op_i)
        OP_WR:   q_o <= wdata_i;
        OP_SET:  q_o <= q_o | wdata_i;
        OP_CLR:  q_o <= q_o & ~wdata_i;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
`timescale 1ns/1ps
module ctl_reg_bank
  import cb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int N_CTRL = 6,
  parameter int N_CFG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int N_AL  = N_CTRL + N_CFG;

  dec_t              dec;
  logic              full_acc;
  logic              wr_hit;
  logic              rd_ok;
  logic              err_d;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] al_q [N_AL];
  logic [DATA_W-1:0] pl_q [N_PLAIN];

  cb_decode #(
    .IDX_W (IDX_W),
    .N_CTRL(N_CTRL),
    .N_CFG (N_CFG)
  ) u_dec (
    .idx_i(addr_i[ADDR_W-1:3]),
    .dec_o(dec)
  );

  assign full_acc = (size_i == SZ_8B) && (addr_i[2:0] == 3'd0);
  assign wr_hit   = req_i && we_i && full_acc && dec.hit;
  assign rd_ok    = req_i && !we_i && full_acc && dec.hit && (dec.op == OP_WR);
  assign err_d    = req_i && (!full_acc || !dec.hit || (!we_i && dec.op != OP_WR));

  for (genvar k = 0; k < N_AL; k++) begin : g_al
    cb_reg #(.DATA_W(DATA_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_hit && dec.aliased && dec.slot == 4'(k)),
      .op_i   (dec.op),
      .wdata_i(wdata_i),
      .q_o    (al_q[k])
    );
  end

  for (genvar p = 0; p < N_PLAIN; p++) begin : g_pl
    cb_reg #(.DATA_W(DATA_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_hit && !dec.aliased && dec.slot == 4'(p)),
      .op_i   (OP_WR),
      .wdata_i(wdata_i),
      .q_o    (pl_q[p])
    );
  end

  always_comb begin
    rd_val = '1;
    for (int k = 0; k < N_AL; k++) begin
      if (dec.aliased && dec.slot == 4'(k)) rd_val = al_q[k];
    end
    for (int p = 0; p < N_PLAIN; p++) begin
      if (!dec.aliased && dec.slot == 4'(p)) rd_val = pl_q[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= err_d;
      if (req_i && !we_i) rdata_o <= rd_ok ? rd_val : '1;
    end
  end
endmodule

// File: rtl/ctl_reg_bank_chk.sv
`timescale 1ns/1ps
module ctl_reg_bank_chk
  import cb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int N_CTRL = 6,
  parameter int N_CFG  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic [DATA_W-1:0] al_q [N_CTRL+N_CFG],
  input logic [DATA_W-1:0] pl_q [N_PLAIN]
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int N_AL  = N_CTRL + N_CFG;

  logic [IDX_W-1:0] idx;
  logic             full;
  logic             alias_idx;
  logic [3:0]       lo;

  assign idx  = addr_i[ADDR_W-1:3];
  assign full = (size_i == 2'd3) && (addr_i[2:0] == 3'd0);
  assign lo   = idx[3:0];
  assign alias_idx = ((idx >> 4) == IDX_W'(1) || (idx >> 4) == IDX_W'(2)) &&
                     (int'(lo) < N_CTRL || (int'(lo) >= CFG_BASE && int'(lo) < CFG_BASE + N_CFG));

  AST_PARTIAL_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !full |=> err_o); // R2

  for (genvar k = 0; k < N_AL; k++) begin : g_kal
    AST_PARTIAL_KEEP_AL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i && we_i && !full |=> $stable(al_q[k])); // R2
  end
  for (genvar p = 0; p < N_PLAIN; p++) begin : g_kpl
    AST_PARTIAL_KEEP_PL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i && we_i && !full |=> $stable(pl_q[p])); // R2
  end

  AST_SET_CTRL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && full && idx == IDX_W'(SET_OFS)
    |=> al_q[0] == ($past(al_q[0]) | $past(wdata_i))); // R5

  AST_CLR_CFG1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && full && idx == IDX_W'(CFG_BASE + 1 + CLR_OFS)
    |=> al_q[N_CTRL+1] == ($past(al_q[N_CTRL+1]) & ~$past(wdata_i))); // R6

  AST_ALIAS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && full && alias_idx |=> err_o && rdata_o == '1); // R7

  AST_STAT_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && full && idx == IDX_W'('h100)
    |=> !err_o && rdata_o == $past(pl_q[0])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rdata_o)); // R10

  AST_IDLE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !err_o); // R11
endmodule

bind ctl_reg_bank ctl_reg_bank_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .N_CTRL(N_CTRL),
  .N_CFG (N_CFG)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .size_i (size_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .err_o  (err_o),
  .al_q   (al_q),
  .pl_q   (pl_q)
);

// File: tb/sim_ctl_reg_bank.sv
`timescale 1ns/1ps
module sim_ctl_reg_bank;
  localparam real CLK_NS = 8.0;
  localparam logic [63:0] ONES = '1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  size_i = 2'd3;
  logic [15:0] addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  ctl_reg_bank u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .size_i (size_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .err_o  (err_o)
  );

  function automatic logic [15:0] ba(int idx);
    return 16'(idx << 3);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one request cycle; outputs sampled at the following falling edge
  task automatic acc(logic w, logic [15:0] a, logic [63:0] d, logic [1:0] sz,
                     output logic [63:0] rd, output logic e);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; size_i = sz;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; size_i = 2'd3;
    rd = rdata_o; e = err_o;
  endtask

  task automatic wr(int idx, logic [63:0] d, string req, logic exp_err);
    logic [63:0] rd; logic e;
    acc(1'b1, ba(idx), d, 2'd3, rd, e);
    chk({req, " write err"}, 64'(e), 64'(exp_err));
  endtask

  task automatic rd_chk(int idx, logic [63:0] exp, logic exp_err, string req);
    logic [63:0] rd; logic e;
    acc(1'b0, ba(idx), '0, 2'd3, rd, e);
    chk({req, " read data"}, rd, exp);
    chk({req, " read err"}, 64'(e), 64'(exp_err));
  endtask

  task automatic t_reset;
    int idxs [12] = '{0, 1, 2, 3, 4, 5, 8, 9, 'h100, 'h101, 'h3FE, 'h3FF};
    chk("R1 rdata", rdata_o, '0);
    chk("R1 err", 64'(err_o), 0);
    foreach (idxs[i]) rd_chk(idxs[i], '0, 1'b0, "R1");
  endtask

  task automatic t_plain;
    wr(3, 64'hDEAD_BEEF_0123_4567, "R3", 1'b0);
    rd_chk(3, 64'hDEAD_BEEF_0123_4567, 1'b0, "R3");
    wr(5, 64'h8000_0000_0000_0001, "R3", 1'b0);
    rd_chk(5, 64'h8000_0000_0000_0001, 1'b0, "R3");
    wr(3, 64'h0000_0000_0000_00AA, "R3", 1'b0);
    rd_chk(3, 64'h0000_0000_0000_00AA, 1'b0, "R3");
    wr(8, 64'h1111_2222_3333_4444, "R4", 1'b0);
    wr(9, 64'h5555_6666_7777_8888, "R4", 1'b0);
    rd_chk(8, 64'h1111_2222_3333_4444, 1'b0, "R4");
    rd_chk(9, 64'h5555_6666_7777_8888, 1'b0, "R4");
  endtask

  task automatic t_set;
    wr(2, 64'h0000_0000_0000_00F0, "R5", 1'b0);
    wr(2 + 'h10, 64'h0000_0000_0000_0F0F, "R5", 1'b0);
    rd_chk(2, 64'h0000_0000_0000_0FFF, 1'b0, "R5");
    wr(8 + 'h10, 64'hF000_0000_0000_0000, "R5", 1'b0);
    rd_chk(8, 64'hF111_2222_3333_4444, 1'b0, "R5");
    wr(0 + 'h10, 64'h0000_0000_0000_0003, "R5", 1'b0);
    rd_chk(0, 64'h0000_0000_0000_0003, 1'b0, "R5");
  endtask

  task automatic t_clr;
    wr(9, ONES, "R6", 1'b0);
    wr(9 + 'h20, 64'h0000_0000_0000_FF00, "R6", 1'b0);
    rd_chk(9, 64'hFFFF_FFFF_FFFF_00FF, 1'b0, "R6");
    wr(5 + 'h20, 64'h8000_0000_0000_0000, "R6", 1'b0);
    rd_chk(5, 64'h0000_0000_0000_0001, 1'b0, "R6");
  endtask

  task automatic t_alias_read;
    rd_chk(0 + 'h10, ONES, 1'b1, "R7");
    rd_chk(9 + 'h20, ONES, 1'b1, "R7");
    rd_chk(0, 64'h0000_0000_0000_0003, 1'b0, "R7 state kept");
    rd_chk(9, 64'hFFFF_FFFF_FFFF_00FF, 1'b0, "R7 state kept");
  endtask

  task automatic t_plain_regs;
    wr('h100, 64'h0123_0000_0000_0001, "R8", 1'b0);
    wr('h101, 64'h0000_4567_0000_0002, "R8", 1'b0);
    wr('h3FE, 64'h0000_0000_89AB_0003, "R8", 1'b0);
    wr('h3FF, 64'hCDEF_0000_0000_0004, "R8", 1'b0);
    rd_chk('h100, 64'h0123_0000_0000_0001, 1'b0, "R8");
    rd_chk('h101, 64'h0000_4567_0000_0002, 1'b0, "R8");
    rd_chk('h3FE, 64'h0000_0000_89AB_0003, 1'b0, "R8");
    rd_chk('h3FF, 64'hCDEF_0000_0000_0004, 1'b0, "R8");
    wr('h110, ONES, "R8 no set alias", 1'b1);
    rd_chk('h100, 64'h0123_0000_0000_0001, 1'b0, "R8 no set alias");
    rd_chk('h121, ONES, 1'b1, "R8 no clear alias");
  endtask

  task automatic t_unmapped;
    rd_chk(7, ONES, 1'b1, "R9");
    rd_chk(6, ONES, 1'b1, "R9");
    wr('h0A, ONES, "R9", 1'b1);
    wr('h30, ONES, "R9", 1'b1);
    rd_chk(8, 64'hF111_2222_3333_4444, 1'b0, "R9 write ignored");
    rd_chk(3, 64'h0000_0000_0000_00AA, 1'b0, "R9 write ignored");
  endtask

  task automatic t_size;
    logic [63:0] rd; logic e;
    acc(1'b1, ba(1), ONES, 2'd2, rd, e);
    chk("R2 short write err", 64'(e), 1);
    acc(1'b1, ba(1) | 16'h4, ONES, 2'd3, rd, e);
    chk("R2 misaligned write err", 64'(e), 1);
    rd_chk(1, '0, 1'b0, "R2 register unchanged");
    acc(1'b0, ba(3), '0, 2'd1, rd, e);
    chk("R2 short read data", rd, ONES);
    chk("R2 short read err", 64'(e), 1);
  endtask

  task automatic t_timing;
    logic [63:0] rd; logic e;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = ba(4); wdata_i = 64'h0BAD_F00D_CAFE_0004;
    @(negedge clk_i);
    we_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R10 read after write", rdata_o, 64'h0BAD_F00D_CAFE_0004);
    chk("R11 err low on good read", 64'(err_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R10 rdata held while idle", rdata_o, 64'h0BAD_F00D_CAFE_0004);
    wr(2, 64'h77, "R10", 1'b0);
    chk("R10 rdata held over write", rdata_o, 64'h0BAD_F00D_CAFE_0004);
    acc(1'b0, ba(7), '0, 2'd3, rd, e);
    chk("R11 err on bad read", 64'(e), 1);
    @(negedge clk_i);
    chk("R11 err is one cycle", 64'(err_o), 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_plain();
    t_set();
    t_clr();
    t_alias_read();
    t_plain_regs();
    t_unmapped();
    t_size();
    t_timing();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule